// File: doc/BRIEF.md
# Intel HEX Record Stream Generator

This block turns a range of memory into Intel HEX text. After a start command that gives a base address and a byte count, it reads the range one byte at a time through a synchronous read port. It sends the text out as a byte-wide valid/ready stream of ASCII characters, which a serial transmitter can take directly. The range is cut into data records of up to 32 bytes each. Every record starts on a new line and carries its own checksum. The text ends with an end-of-file record followed by a line break, and then a done flag goes high.

Nothing is buffered inside the block. Each record is formatted and checksummed on the fly, one byte at a time. The output side may stall for any number of cycles, and the block waits without losing or changing a character.

Top module: `ihex_stream_gen`

## Requirements
- R1: While reset is held and after it is released, out_valid, mem_rd_en and done are all low until a start is accepted.
- R2: Each record, whether data or end-of-file, is preceded by carriage return 0x0D and line feed 0x0A, and then the colon 0x3A.
- R3: A range of N bytes becomes ceil(N/32) data records. Every record except the last holds 32 bytes, and the last holds the remainder. Each record's load address is the previous record's address plus its length, modulo 2^16.
- R4: After the colon, a data record carries these fields in this order: byte count (2 digits), load address (4 digits, high byte first), type "00", each data byte as 2 digits in ascending address order, and checksum (2 digits).
- R5: The checksum is 256 minus the low 8 bits of the sum of the count byte, both address bytes, the type byte and all data bytes, taken modulo 256.
- R6: Each nibble is sent as the ASCII codes 0x30-0x39 for values 0-9 and 0x41-0x46 for values 10-15, so only uppercase letters appear.
- R7: After the last data record, the block sends CR LF ":00000001FF" CR LF. It then raises done and holds it with out_valid and mem_rd_en low until the next start.
- R8: A start with a byte count of zero produces exactly the 15 characters CR LF ":00000001FF" CR LF, followed by done.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change on the next cycle.
- R10: Each data byte is read once, at ascending addresses from the start address. mem_rd_data is captured exactly one cycle after mem_rd_en. No read happens while out_valid is high, and within a record the next read follows only after both digits of the previous byte have been accepted.
- R11: A start accepted from idle or from done clears done in the next cycle. A start pulse that arrives while a transfer is running is ignored and does not change the text produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when not busy) |
| start_addr | input | 16 | First memory address of the range |
| byte_len | input | LEN_W (16) | Number of bytes to dump |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after mem_rd_en |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | Sink accepts the character |
| out_data | output | 8 | ASCII character |
| done | output | 1 | Transfer finished (level) |

## Verification
The assertions assume that the memory returns its data exactly one cycle after a read strobe. They also assume that the sink may drop out_ready at any time but never takes a character unless out_valid is high. The bench memory model drives a fixed junk value in every cycle that follows no read, so a capture in the wrong cycle corrupts the text. It also drives out_ready with always-on, pseudo-random and one-in-three patterns. Start pulses are applied from idle or done, and on purpose once mid-transfer, so that the ignore rule is exercised.

// File: rtl/ihex_pkg.sv
package ihex_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CR,
        ST_LF,
        ST_COLON,
        ST_HI,
        ST_LO,
        ST_RD,
        ST_RDW
    } ihex_state_e;

    typedef enum logic [2:0] {
        FLD_CNT,
        FLD_AH,
        FLD_AL,
        FLD_TYP,
        FLD_DAT,
        FLD_SUM
    } ihex_field_e;

    localparam logic [7:0] CHR_CR    = 8'h0D;
    localparam logic [7:0] CHR_LF    = 8'h0A;
    localparam logic [7:0] CHR_COLON = 8'h3A;

    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) begin
            return {4'h0, n} + 8'h30;
        end
        return {4'h0, n} + 8'h37;
    endfunction

endpackage

// File: rtl/ihex_hexdigit.sv
module ihex_hexdigit
    import ihex_pkg::*;
(
    input  logic [3:0] nib,
    output logic [7:0] chr
);
    assign chr = nib_to_ascii(nib);
endmodule

// File: rtl/ihex_rec_plan.sv
module ihex_rec_plan #(
    parameter int LEN_W   = 16,
    parameter int MAX_REC = 32,
    parameter int CNT_W   = $clog2(MAX_REC + 1)
) (
    input  logic [LEN_W-1:0] remain,
    output logic [CNT_W-1:0] rec_len,
    output logic             is_eof
);
    assign is_eof  = (remain == '0);
    assign rec_len = (remain > LEN_W'(MAX_REC)) ? CNT_W'(MAX_REC)
                                                : remain[CNT_W-1:0];
endmodule

// File: rtl/ihex_checksum.sv
module ihex_checksum (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       add_en,
    input  logic [7:0] add_byte,
    output logic [7:0] csum
);
    logic [7:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= 8'h00;
        end else if (add_en) begin
            sum_q <= sum_q + add_byte;
        end
    end

    assign csum = 8'h00 - sum_q;
endmodule

// File: rtl/ihex_stream_gen.sv
module ihex_stream_gen
    import ihex_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_REC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      start_addr,
    input  logic [LEN_W-1:0] byte_len,
    output logic             mem_rd_en,
    output logic [15:0]      mem_rd_addr,
    input  logic [7:0]       mem_rd_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             done
);
    localparam int CNT_W = $clog2(MAX_REC + 1);

    ihex_state_e      st;
    ihex_field_e      fld;
    logic [7:0]       fld_byte;
    logic [15:0]      rec_addr;
    logic [15:0]      cur_addr;
    logic [LEN_W-1:0] remain;
    logic [CNT_W-1:0] data_left;
    logic             eof_rec;
    logic             tail;
    logic             done_q;

    logic [CNT_W-1:0] plan_len;
    logic             plan_eof;
    logic [7:0]       csum;
    logic [7:0]       src_byte;
    logic [3:0]       nib;
    logic [7:0]       digit_chr;
    logic             fire;

    ihex_rec_plan #(.LEN_W(LEN_W), .MAX_REC(MAX_REC), .CNT_W(CNT_W)) u_plan (
        .remain (remain),
        .rec_len(plan_len),
        .is_eof (plan_eof)
    );

    ihex_checksum u_csum (
        .clk     (clk),
        .rst     (rst),
        .clr     (st == ST_LF && fire),
        .add_en  (st == ST_LO && fire && fld != FLD_SUM),
        .add_byte(fld_byte),
        .csum    (csum)
    );

    assign src_byte = (fld == FLD_SUM) ? csum : fld_byte;
    assign nib      = (st == ST_LO) ? src_byte[3:0] : src_byte[7:4];

    ihex_hexdigit u_digit (
        .nib(nib),
        .chr(digit_chr)
    );

    always_comb begin
        out_valid = 1'b1;
        case (st)
            ST_CR:        out_data = CHR_CR;
            ST_LF:        out_data = CHR_LF;
            ST_COLON:     out_data = CHR_COLON;
            ST_HI, ST_LO: out_data = digit_chr;
            default: begin
                out_data  = 8'h00;
                out_valid = 1'b0;
            end
        endcase
    end

    assign fire        = out_valid && out_ready;
    assign mem_rd_en   = (st == ST_RD);
    assign mem_rd_addr = cur_addr;
    assign done        = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            fld       <= FLD_CNT;
            fld_byte  <= 8'h00;
            rec_addr  <= 16'h0000;
            cur_addr  <= 16'h0000;
            remain    <= '0;
            data_left <= '0;
            eof_rec   <= 1'b0;
            tail      <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    cur_addr <= start_addr;
                    remain   <= byte_len;
                    done_q   <= 1'b0;
                    tail     <= 1'b0;
                    st       <= ST_CR;
                end
                ST_CR: if (fire) st <= ST_LF;
                ST_LF: if (fire) begin
                    if (tail) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        st        <= ST_COLON;
                        eof_rec   <= plan_eof;
                        data_left <= plan_len;
                        rec_addr  <= plan_eof ? 16'h0000 : cur_addr;
                        fld       <= FLD_CNT;
                        fld_byte  <= 8'(plan_len);
                    end
                end
                ST_COLON: if (fire) st <= ST_HI;
                ST_HI:    if (fire) st <= ST_LO;
                ST_LO: if (fire) begin
                    case (fld)
                        FLD_CNT: begin
                            fld      <= FLD_AH;
                            fld_byte <= rec_addr[15:8];
                            st       <= ST_HI;
                        end
                        FLD_AH: begin
                            fld      <= FLD_AL;
                            fld_byte <= rec_addr[7:0];
                            st       <= ST_HI;
                        end
                        FLD_AL: begin
                            fld      <= FLD_TYP;
                            fld_byte <= {7'd0, eof_rec};
                            st       <= ST_HI;
                        end
                        FLD_TYP, FLD_DAT: begin
                            if (data_left != '0) begin
                                fld <= FLD_DAT;
                                st  <= ST_RD;
                            end else begin
                                fld <= FLD_SUM;
                                st  <= ST_HI;
                            end
                        end
                        default: begin
                            st   <= ST_CR;
                            tail <= eof_rec;
                        end
                    endcase
                end
                ST_RD: begin
                    cur_addr  <= cur_addr + 16'd1;
                    remain    <= remain - LEN_W'(1);
                    data_left <= data_left - CNT_W'(1);
                    st        <= ST_RDW;
                end
                ST_RDW: begin
                    fld_byte <= mem_rd_data;
                    st       <= ST_HI;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en); // R10

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !out_valid); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid && !mem_rd_en); // R7

    AST_HEX_UPPER: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HI || st == ST_LO) |->
            ((digit_chr >= 8'h30 && digit_chr <= 8'h39) ||
             (digit_chr >= 8'h41 && digit_chr <= 8'h46))); // R6

    AST_REC_LIMIT: assert property (@(posedge clk) disable iff (rst)
        st == ST_COLON |-> data_left <= CNT_W'(MAX_REC)); // R3

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) && !done |=> !done || $past(st == ST_LF && tail)); // R11

endmodule

// File: tb/ihex_stream_gen_bench.sv
module ihex_stream_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [15:0] V_ADDR [NV] = '{16'h0100, 16'h0200, 16'h1234,
                                           16'h0FF0, 16'hFFF0, 16'h4000};
    localparam int V_LEN   [NV] = '{0, 1, 32, 33, 70, 64};
    localparam int V_MODE  [NV] = '{0, 1, 2, 1, 2, 0};
    localparam int V_BYTES [NV] = '{15, 30, 92, 107, 194, 169};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] start_addr = 16'h0;
    logic [15:0] byte_len = 16'h0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        done;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    logic [7:0] lfsr = 8'hB7;
    int cyc = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    logic [15:0] exp_rd_addr = 16'h0;
    int rd_cnt = 0;
    int hs_since = 0;
    logic hold_pend = 1'b0;
    logic [7:0] hold_data = 8'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ihex_stream_gen u_ihex_stream_gen (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);
        else           mem_rd_data <= 8'hEE;
    end

    function automatic logic [7:0] hc(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return 8'h41 + {4'h0, n} - 8'd10;
    endfunction

    task automatic push_hex(input logic [7:0] b);
        exp_q.push_back(hc(b[7:4]));
        exp_q.push_back(hc(b[3:0]));
    endtask

    task automatic build_exp(input logic [15:0] a, input int n);
        int left;
        logic [15:0] p;
        logic [7:0] sum;
        string eofs;
        exp_q.delete();
        left = n;
        p = a;
        while (left > 0) begin
            int k;
            k = (left > 32) ? 32 : left;
            exp_q.push_back(8'h0D); exp_q.push_back(8'h0A); exp_q.push_back(8'h3A);
            sum = 8'(k) + p[15:8] + p[7:0];
            push_hex(8'(k)); push_hex(p[15:8]); push_hex(p[7:0]); push_hex(8'h00);
            for (int i = 0; i < k; i++) begin
                logic [7:0] b;
                b = memf(p + 16'(i));
                sum = sum + b;
                push_hex(b);
            end
            push_hex(8'h00 - sum);
            p = p + 16'(k);
            left = left - k;
        end
        eofs = "\r\n:00000001FF\r\n";
        for (int i = 0; i < eofs.len(); i++) exp_q.push_back(eofs[i]);
    endtask

    // output monitor, ready driver, read-port checker
    always begin
        @(negedge clk);
        cyc++;
        case (ready_mode)
            1:       out_ready = lfsr[0];
            2:       out_ready = (cyc % 3 == 0);
            default: out_ready = 1'b1;
        endcase
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1;
        if (rst) begin
            hold_pend = 1'b0;
        end else begin
            if (hold_pend) begin
                checks++;
                if (!(out_valid && out_data == hold_data)) begin
                    errors++;
                    $display("FAIL R9 stalled byte changed: got valid=%0b data=%h expected valid=1 data=%h",
                             out_valid, out_data, hold_data);
                end
            end
            hold_pend = out_valid && !out_ready;
            hold_data = out_data;
            if (out_valid && out_ready) begin
                got_q.push_back(out_data);
                hs_since++;
            end
            if (mem_rd_en) begin
                checks++;
                if (mem_rd_addr !== exp_rd_addr || out_valid || (rd_cnt > 0 && hs_since < 2)) begin
                    errors++;
                    $display("FAIL R10 read: got addr=%h valid=%0b gap=%0d expected addr=%h valid=0 gap>=2",
                             mem_rd_addr, out_valid, hs_since, exp_rd_addr);
                end
                hs_since = 0;
                rd_cnt++;
                exp_rd_addr = exp_rd_addr + 16'd1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic run_job(input logic [15:0] a, input int n, input int mode,
                           input int nbytes, input bit inject);
        int t;
        int mism;
        int lower;
        build_exp(a, n);
        got_q.delete();
        exp_rd_addr = a;
        rd_cnt = 0;
        hs_since = 0;
        ready_mode = mode;
        @(negedge clk);
        start = 1'b1; start_addr = a; byte_len = 16'(n);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R11", "done cleared after start", int'(done), 0);
        if (inject) begin
            repeat (6) @(negedge clk);
            start = 1'b1; start_addr = 16'h9999; byte_len = 16'd40;
            @(negedge clk);
            start = 1'b0; start_addr = 16'h0; byte_len = 16'h0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R7", "done raised", int'(done), 1);
        check(got_q.size() == nbytes, (n == 0) ? "R8" : "R3", "character count",
              got_q.size(), nbytes);
        mism = -1;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            if (mism < 0 && got_q[i] != exp_q[i]) mism = i;
        end
        checks++;
        if (mism >= 0) begin
            errors++;
            $display("FAIL R4/R5 stream byte %0d: got %h expected %h", mism, got_q[mism], exp_q[mism]);
        end
        lower = 0;
        foreach (got_q[i]) if (got_q[i] >= 8'h61 && got_q[i] <= 8'h66) lower++;
        check(lower == 0, "R6", "lowercase digits", lower, 0);
        check(rd_cnt == n, "R10", "read count", rd_cnt, n);
        if (got_q.size() >= 15) begin
            int base;
            logic [7:0] tail_ok;
            base = got_q.size() - 15;
            tail_ok = 8'd1;
            for (int i = 0; i < 15; i++) if (got_q[base + i] != exp_q[exp_q.size() - 15 + i]) tail_ok = 8'd0;
            check(tail_ok == 8'd1, "R7", "end record text", int'(tail_ok), 1);
            check(got_q[0] == 8'h0D && got_q[1] == 8'h0A && got_q[2] == 8'h3A, "R2",
                  "record lead-in first char", int'(got_q[0]), 13);
        end
        repeat (3) @(negedge clk);
        check(done && !out_valid && !mem_rd_en, "R7", "quiet while done",
              int'({done, out_valid, mem_rd_en}), 4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!out_valid && !mem_rd_en && !done, "R1", "outputs in reset",
              int'({out_valid, mem_rd_en, done}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!out_valid && !mem_rd_en && !done, "R1", "outputs after reset",
              int'({out_valid, mem_rd_en, done}), 0);

        for (int v = 0; v < NV; v++) begin
            run_job(V_ADDR[v], V_LEN[v], V_MODE[v], V_BYTES[v], 1'b0);
        end

        // R11: start mid-transfer ignored
        run_job(16'h0300, 5, 1, 38, 1'b1);
        // R8: zero length back to back from done, with stalls
        run_job(16'hABCD, 0, 2, 15, 1'b0);

        // R1: reset in the middle of a transfer
        ready_mode = 1;
        @(negedge clk);
        start = 1'b1; start_addr = 16'h2000; byte_len = 16'd50;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !mem_rd_en && !done, "R1", "outputs after mid-run reset",
              int'({out_valid, mem_rd_en, done}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule